// File: doc/BRIEF.md
# Windowed Threshold Persistence Interrupt

This block watches a stream of 16-bit conversion results and decides when to interrupt a host. Each result that arrives with its valid strobe is compared against a programmable window, set by a low and a high threshold. A result outside that window increments a count of consecutive out-of-window results. A result inside the window sets the count back to zero. When the count reaches a 4-bit persistence setting, the block latches an interrupt. A persistence of zero instead requests an interrupt on every result, whatever its value.

The host programs the block with byte-wide register writes. Two byte registers form each 16-bit threshold, and one control byte holds a 2-bit mode and the persistence. The mode selects the interrupt style:
- 00: the interrupt is off.
- 01: level style, released by a clear pulse.
- 10: alert style, which also sets a pending flag for an alert responder. The interrupt is released by a clear pulse or by a won alert-response cycle.
- 11: the control write itself forces the interrupt, which then behaves as in alert style.

The interrupt output is active-low. Only the one result channel fed to the block is compared.

Top module: `thr_persist_irq`

## Requirements
- R1: After a synchronous reset, `irq_n` is 1, `alert_pend` is 0, both thresholds are 0 and the control byte is 0 (mode 00, persistence 0).
- R2: A write to address 2 sets bits 7:0 and address 3 sets bits 15:8 of the low threshold. A write to address 4 sets bits 7:0 and address 5 sets bits 15:8 of the high threshold. Address 6 is the control byte: mode in bits 5:4, persistence in bits 3:0, bits 7:6 discarded.
- R3: A result is out of window only when it is strictly below the low threshold or strictly above the high threshold. A result equal to either threshold is in window.
- R4: With persistence 0 and mode not 00, every valid result latches the interrupt, even when the result is in window.
- R5: With persistence N (1 to 15), the interrupt latches on the edge that takes the Nth consecutive out-of-window result, and not on an earlier one.
- R6: An in-window result returns the consecutive count to zero.
- R7: The consecutive count saturates at 15 and does not wrap.
- R8: In mode 01 the latched interrupt drives `irq_n` low until `clr_req` is seen. `alert_won` has no effect, and `alert_pend` stays 0.
- R9: In mode 10 a latched interrupt also raises `alert_pend`. Either `clr_req` or `alert_won` releases both.
- R10: In mode 00 no interrupt is raised, but the consecutive count keeps tracking results. Writing mode 00 drops any latched interrupt.
- R11: Writing the control byte with mode 11 latches the interrupt and `alert_pend` on the same edge. A following `alert_won` releases it.
- R12: When a new interrupt condition and `clr_req` arrive on the same edge, the interrupt stays latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register byte address |
| wr_data | input | 8 | Register write data |
| res_valid | input | 1 | Conversion result valid strobe |
| res_value | input | 16 | Conversion result |
| clr_req | input | 1 | Interrupt clear pulse |
| alert_won | input | 1 | Alert-response cycle won by this block |
| irq_n | output | 1 | Active-low interrupt |
| alert_pend | output | 1 | Alert-style interrupt pending |

## Verification
The bench targets the window edges:
- A result equal to a threshold must not count. A design that compares with less-or-equal interrupts one result early.
- It checks that an in-window result breaks a run. If the count is kept instead of reset, the interrupt fires on the next out-of-window result.

It drives seventeen consecutive out-of-window results at persistence 15. A counter that wraps to zero would then miss the interrupt on the following result.

It also covers the mode rules:
- It presents clear and trigger on the same edge. A design where the clear takes priority would lose that interrupt.
- It sends `alert_won` in level mode. A design that honours it there would release the interrupt.
- It writes mode 11 and checks that `alert_pend` rises on the write edge.

// File: rtl/thr_irq_pkg.sv
package thr_irq_pkg;

    localparam int RES_W  = 16;
    localparam int PERS_W = 4;
    localparam int BYTE_W = 8;
    localparam int LANES  = RES_W / BYTE_W;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_LEVEL = 2'b01,
        MODE_ALERT = 2'b10,
        MODE_FORCE = 2'b11
    } irq_mode_e;

    typedef struct packed {
        irq_mode_e          mode;
        logic [PERS_W-1:0]  persist;
    } irq_ctrl_t;

    typedef struct packed {
        logic [RES_W-1:0] lo;
        logic [RES_W-1:0] hi;
    } win_cfg_t;

    function automatic logic outside_win(input logic [RES_W-1:0] v, input win_cfg_t w);
        return (v < w.lo) || (v > w.hi);
    endfunction

    function automatic logic [PERS_W-1:0] sat_inc(input logic [PERS_W-1:0] c);
        return (&c) ? c : c + 1'b1;
    endfunction

    function automatic irq_ctrl_t unpack_ctrl(input logic [BYTE_W-1:0] b);
        irq_ctrl_t r;
        r.mode    = irq_mode_e'(b[5:4]);
        r.persist = b[PERS_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/thr_cfg_regs.sv
module thr_cfg_regs
    import thr_irq_pkg::*;
#(
    parameter int ADDR_W    = 3,
    parameter int LO_BASE   = 2,
    parameter int HI_BASE   = 4,
    parameter int CTRL_ADDR = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output win_cfg_t          win,
    output irq_ctrl_t         ctrl,
    output logic              ctrl_wr,
    output irq_ctrl_t         ctrl_new
);

    logic [LANES-1:0][BYTE_W-1:0] lo_b, hi_b;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LO_BASE + g);
        localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(HI_BASE + g);
        always_ff @(posedge clk) begin
            if (rst) begin
                lo_b[g] <= '0;
                hi_b[g] <= '0;
            end else if (wr_en) begin
                if (wr_addr == LO_A) lo_b[g] <= wr_data;
                if (wr_addr == HI_A) hi_b[g] <= wr_data;
            end
        end
    end

    assign win.lo = lo_b;
    assign win.hi = hi_b;

    assign ctrl_wr  = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
    assign ctrl_new = unpack_ctrl(wr_data);

    always_ff @(posedge clk) begin
        if (rst) ctrl <= '{mode: MODE_OFF, persist: '0};
        else if (ctrl_wr) ctrl <= ctrl_new;
    end

    // R2
    ctrl_load_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> ctrl == $past(ctrl_new));

endmodule

// File: rtl/thr_persist_cnt.sv
module thr_persist_cnt
    import thr_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              res_valid,
    input  logic [RES_W-1:0]  res_value,
    input  win_cfg_t          win,
    input  logic [PERS_W-1:0] persist,
    output logic              hit
);

    logic              is_out;
    logic [PERS_W-1:0] cnt_q, cnt_d;

    assign is_out = outside_win(res_value, win);

    always_comb begin
        cnt_d = cnt_q;
        if (res_valid) cnt_d = is_out ? sat_inc(cnt_q) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign hit = res_valid && ((persist == '0) || (is_out && (cnt_d >= persist)));

    // R6
    inwin_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !is_out) |=> cnt_q == '0);

    // R7
    cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && is_out && (&cnt_q)) |=> (&cnt_q));

    // R5
    no_early_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && persist != '0) |-> is_out);

endmodule

// File: rtl/thr_irq_latch.sv
module thr_irq_latch
    import thr_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  irq_ctrl_t ctrl,
    input  logic      ctrl_wr,
    input  irq_ctrl_t ctrl_new,
    input  logic      hit,
    input  logic      clr_req,
    input  logic      alert_won,
    output logic      flag,
    output logic      pend
);

    logic set_c, rel_c, drop_c;

    assign drop_c = ctrl_wr && (ctrl_new.mode == MODE_OFF);
    assign set_c  = (ctrl_wr && ctrl_new.mode == MODE_FORCE) ||
                    (hit && ctrl.mode != MODE_OFF);
    assign rel_c  = clr_req || (alert_won && ctrl.mode[1]);

    always_ff @(posedge clk) begin
        if (rst)         flag <= 1'b0;
        else if (drop_c) flag <= 1'b0;
        else if (set_c)  flag <= 1'b1;
        else if (rel_c)  flag <= 1'b0;
    end

    assign pend = flag && ctrl.mode[1];

    // R12
    trig_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (set_c && !drop_c) |=> flag);

    // R8
    level_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flag && ctrl.mode == MODE_LEVEL && !clr_req && !ctrl_wr) |=> flag);

    // R10
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == MODE_OFF && !ctrl_wr) |=> !flag);

endmodule

// File: rtl/thr_persist_irq.sv
module thr_persist_irq
    import thr_irq_pkg::*;
#(
    parameter int ADDR_W    = 3,
    parameter int LO_BASE   = 2,
    parameter int HI_BASE   = 4,
    parameter int CTRL_ADDR = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              res_valid,
    input  logic [15:0]       res_value,
    input  logic              clr_req,
    input  logic              alert_won,
    output logic              irq_n,
    output logic              alert_pend
);

    win_cfg_t  win;
    irq_ctrl_t ctrl, ctrl_new;
    logic      ctrl_wr, hit, flag;

    thr_cfg_regs #(
        .ADDR_W(ADDR_W), .LO_BASE(LO_BASE), .HI_BASE(HI_BASE), .CTRL_ADDR(CTRL_ADDR)
    ) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .win(win), .ctrl(ctrl), .ctrl_wr(ctrl_wr), .ctrl_new(ctrl_new)
    );

    thr_persist_cnt u_cnt (
        .clk(clk), .rst(rst), .res_valid(res_valid), .res_value(res_value),
        .win(win), .persist(ctrl.persist), .hit(hit)
    );

    thr_irq_latch u_latch (
        .clk(clk), .rst(rst), .ctrl(ctrl), .ctrl_wr(ctrl_wr), .ctrl_new(ctrl_new),
        .hit(hit), .clr_req(clr_req), .alert_won(alert_won),
        .flag(flag), .pend(alert_pend)
    );

    assign irq_n = ~flag;

    // R9
    pend_implies_irq_chk: assert property (@(posedge clk) disable iff (rst)
        alert_pend |-> !irq_n);

    // R11
    force_write_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && ctrl_new.mode == MODE_FORCE) |=> alert_pend);

endmodule

// File: tb/thr_persist_irq_tb.sv
module thr_persist_irq_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [7:0]  wr_data;
    logic        res_valid;
    logic [15:0] res_value;
    logic        clr_req;
    logic        alert_won;
    logic        irq_n;
    logic        alert_pend;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic  n;
        logic  p;
        string tag;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    thr_persist_irq u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .res_valid(res_valid), .res_value(res_value), .clr_req(clr_req),
        .alert_won(alert_won), .irq_n(irq_n), .alert_pend(alert_pend)
    );

    // monitor: pops one expectation per cycle after the edge settles
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (irq_n !== e.n || alert_pend !== e.p) begin
                fails++;
                $display("FAIL %s: irq_n=%b alert_pend=%b expected irq_n=%b alert_pend=%b",
                         e.tag, irq_n, alert_pend, e.n, e.p);
            end
        end
    end

    task automatic drive(input logic we, input logic [2:0] a, input logic [7:0] d,
                         input logic rv, input logic [15:0] v,
                         input logic clr, input logic won,
                         input logic en, input logic ep, input string tag);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d;
        res_valid = rv; res_value = v; clr_req = clr; alert_won = won;
        @(posedge clk);
        #1;
        sb.push_back('{n: en, p: ep, tag: tag});
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d,
                      input logic en, input logic ep, input string tag);
        drive(1'b1, a, d, 1'b0, 16'h0, 1'b0, 1'b0, en, ep, tag);
    endtask

    task automatic res(input logic [15:0] v, input logic en, input logic ep, input string tag);
        drive(1'b0, 3'd0, 8'h0, 1'b1, v, 1'b0, 1'b0, en, ep, tag);
    endtask

    task automatic clr(input logic en, input logic ep, input string tag);
        drive(1'b0, 3'd0, 8'h0, 1'b0, 16'h0, 1'b1, 1'b0, en, ep, tag);
    endtask

    task automatic won(input logic en, input logic ep, input string tag);
        drive(1'b0, 3'd0, 8'h0, 1'b0, 16'h0, 1'b0, 1'b1, en, ep, tag);
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 0; wr_addr = 0; wr_data = 0;
        res_valid = 0; res_value = 0; clr_req = 0; alert_won = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        drive(0, 0, 0, 0, 0, 0, 0, 1'b1, 1'b0, "R1 reset state");

        // R2: low = 0x0100, high = 0x8000, level mode, persistence 2
        wr(3'd2, 8'h00, 1, 0, "R2 lo byte");
        wr(3'd3, 8'h01, 1, 0, "R2 lo upper");
        wr(3'd4, 8'h00, 1, 0, "R2 hi byte");
        wr(3'd5, 8'h80, 1, 0, "R2 hi upper");
        wr(3'd6, 8'h12, 1, 0, "R2 ctrl");

        // R3: equality is in window
        res(16'h0100, 1, 0, "R3 equal low");
        res(16'h8000, 1, 0, "R3 equal high");
        // R5: fires on second consecutive out-of-window
        res(16'h00FF, 1, 0, "R5 first out");
        res(16'h8001, 0, 0, "R5 second out");
        // R8: level mode ignores alert_won
        won(0, 0, "R8 alert_won ignored");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 holds");
        clr(1, 0, "R8 clear");

        // R6: in-window breaks the run
        res(16'h4000, 1, 0, "R6 in window");
        res(16'h0000, 1, 0, "R6 out after reset");
        res(16'h4000, 1, 0, "R6 in again");
        res(16'hFFFF, 1, 0, "R6 run restarted");
        res(16'hFFFF, 0, 0, "R6 second fires");
        clr(1, 0, "R6 clear");

        // R4: persistence 0 fires on in-window result
        wr(3'd6, 8'h10, 1, 0, "R4 ctrl");
        res(16'h4000, 0, 0, "R4 every result");
        clr(1, 0, "R4 clear");

        // R12: trigger and clear together
        drive(0, 0, 0, 1, 16'h4000, 1, 0, 0, 0, "R12 trigger wins");
        clr(1, 0, "R12 clear");

        // R9: alert mode, persistence 1
        wr(3'd6, 8'h21, 1, 0, "R9 ctrl");
        res(16'h4000, 1, 0, "R9 in window");
        res(16'h0000, 0, 1, "R9 pending");
        won(1, 0, "R9 alert_won clears");
        res(16'hFFFF, 0, 1, "R9 pending again");
        clr(1, 0, "R9 clr clears");

        // R10: off mode keeps counting
        res(16'h4000, 1, 0, "R10 reset run");
        wr(3'd6, 8'h03, 1, 0, "R10 ctrl off");
        res(16'h0000, 1, 0, "R10 off no irq 1");
        res(16'h0000, 1, 0, "R10 off no irq 2");
        wr(3'd6, 8'h13, 1, 0, "R10 level p3");
        res(16'h0000, 0, 0, "R10 count carried");
        clr(1, 0, "R10 clear");

        // R7: persistence 15 and saturation
        res(16'h4000, 1, 0, "R7 reset run");
        wr(3'd6, 8'h1F, 1, 0, "R7 ctrl");
        for (int i = 1; i < 15; i++) res(16'h0000, 1, 0, "R5 below fifteen");
        res(16'h0000, 0, 0, "R5 fifteenth");
        res(16'h0000, 0, 0, "R7 sixteenth");
        res(16'h0000, 0, 0, "R7 seventeenth");
        clr(1, 0, "R7 clear");
        res(16'h0000, 0, 0, "R7 saturated fires");
        clr(1, 0, "R7 clear again");

        // R11: forced mode
        wr(3'd6, 8'h30, 0, 1, "R11 force on write");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 1, "R11 holds");
        won(1, 0, "R11 alert_won clears");
        wr(3'd6, 8'h30, 0, 1, "R11 force again");
        wr(3'd6, 8'h00, 1, 0, "R10 off drops latch");

        drive(0, 0, 0, 0, 0, 0, 0, 1, 0, "R1 idle");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule